// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block is a watchdog for a system that must prove it is alive at regular intervals. It runs on the fast system clock. A slow tick strobe (nominally 1.024 kHz) advances its counter. Software restarts the count with a kick request. If no kick arrives in time, the block raises a one-cycle system reset request. An optional window mode also treats a kick that comes too early as a fault. A closed phase of programmable length must pass before a kick is welcome. The open phase that follows is the only place a kick is accepted.

An early warning flag can be raised a programmable number of ticks after each restart. Software uses it to learn that the deadline is near. The flag is gated by an interrupt enable. It holds until software writes a one to clear it.

Configuration arrives through separate write strobes per field. Timing fields are locked while the watchdog runs. An always-on bit, once set, stops software from switching the watchdog off. The power-on values of the control and timing fields come from input pins that model stored defaults. Every field reads back on an output.

Top module: `wwd_top`

## Requirements
- R1: On reset the enable, always-on, window-enable, period, window and offset fields take the values on the dflt_* inputs. The interrupt enable, the warning flag and the reset request read zero.
- R2: While enable_o is 1, writes to period, window, offset and window-enable leave those fields unchanged. While enable_o is 0, the same writes update them at the next clock edge.
- R3: A control write with ctrl_enable=1 sets enable_o. A control write with ctrl_enable=0 clears it only if always-on is 0 after that write. Always-on is set by writing 1 and is cleared only by reset.
- R4: A 4-bit code c selects BASE_TICKS·2^min(c,11) ticks, so codes 12 to 15 act as 11. In normal mode (window-enable 0), a reset request is raised after that many ticks with no kick. The request lasts one cycle and the count restarts from zero.
- R5: In normal mode a kick is accepted at any count and restarts the count. A kick in the same cycle as the expiring tick wins: no reset request is raised.
- R6: In window mode a kick while fewer than T(window) ticks have passed since the last restart raises a reset request and restarts the count.
- R7: In window mode a kick at or after T(window) ticks restarts the count without a request. With no kick, a request is raised after T(window)+T(period) ticks.
- R8: The warning flag sets when the count since restart reaches T(offset) ticks and the interrupt enable is 1. It fires at most once per restart. It stays set until ew_clr is pulsed. A set in the same cycle as ew_clr wins.
- R9: While disabled the counter holds at zero, kicks are ignored and no reset request is raised.
- R10: Outputs are registered. A request or flag caused by the tick or kick present at a clock edge appears in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Slow tick strobe, one cycle per tick |
| kick | input | 1 | Restart (clear) request from software |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_enable | input | 1 | Enable value for a control write |
| ctrl_always_on | input | 1 | Always-on value for a control write (1 sets) |
| ctrl_win_en | input | 1 | Window-enable value for a control write |
| cfg_we | input | 1 | Period/window write strobe |
| cfg_period | input | 4 | Time-out period code |
| cfg_window | input | 4 | Closed-window period code |
| ew_we | input | 1 | Warning offset write strobe |
| ew_offset | input | 4 | Warning offset code |
| ie_we | input | 1 | Interrupt enable write strobe |
| ie_val | input | 1 | Interrupt enable value |
| ew_clr | input | 1 | Write-one-to-clear for the warning flag |
| dflt_enable | input | 1 | Power-on enable default |
| dflt_always_on | input | 1 | Power-on always-on default |
| dflt_win_en | input | 1 | Power-on window-enable default |
| dflt_period | input | 4 | Power-on period code default |
| dflt_window | input | 4 | Power-on window code default |
| dflt_offset | input | 4 | Power-on offset code default |
| enable_o | output | 1 | Current enable |
| always_on_o | output | 1 | Current always-on |
| win_en_o | output | 1 | Current window-enable |
| period_o | output | 4 | Current period code |
| window_o | output | 4 | Current window code |
| offset_o | output | 4 | Current offset code |
| irq_en_o | output | 1 | Current interrupt enable |
| sys_rst_req | output | 1 | One-cycle system reset request |
| ew_flag | output | 1 | Early warning flag |

## Verification
A kick and the tick that would complete the period can land in the same cycle. The bench provokes this by counting exactly period-minus-one ticks after a restart and then driving the kick together with the next tick. It passes only if no reset request follows and the count restarts. A warning set and a software clear can also coincide. A behavioural model clocked alongside the design resolves both collisions by the stated priorities, and every output is compared against it in each cycle.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

  localparam int CODE_W   = 4;
  localparam int TOP_CODE = 11;

  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic  enable;
    logic  always_on;
    logic  win_en;
    code_t period;
    code_t window;
    code_t offset;
    logic  irq_en;
  } wwd_cfg_t;

endpackage

// File: rtl/wwd_period_dec.sv
module wwd_period_dec #(
  parameter int BASE_TICKS = 8,
  parameter int CNT_W      = 16
) (
  input  logic [wwd_pkg::CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]           ticks_o
);
  import wwd_pkg::*;

  code_t sat;

  always_comb begin
    sat     = (code_i > code_t'(TOP_CODE)) ? code_t'(TOP_CODE) : code_i;
    ticks_o = CNT_W'(BASE_TICKS) << sat;
  end

endmodule

// File: rtl/wwd_cfg_regs.sv
module wwd_cfg_regs (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  logic             ctrl_enable,
  input  logic             ctrl_always_on,
  input  logic             ctrl_win_en,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_period,
  input  logic [3:0]       cfg_window,
  input  logic             ew_we,
  input  logic [3:0]       ew_offset,
  input  logic             ie_we,
  input  logic             ie_val,
  input  logic             dflt_enable,
  input  logic             dflt_always_on,
  input  logic             dflt_win_en,
  input  logic [3:0]       dflt_period,
  input  logic [3:0]       dflt_window,
  input  logic [3:0]       dflt_offset,
  output wwd_pkg::wwd_cfg_t cfg_o
);
  import wwd_pkg::*;

  wwd_cfg_t r;
  logic     ao_next;
  logic     unlocked;

  always_comb begin
    ao_next  = r.always_on | (ctrl_we & ctrl_always_on);
    unlocked = ~r.enable;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r.enable    <= dflt_enable;
      r.always_on <= dflt_always_on;
      r.win_en    <= dflt_win_en;
      r.period    <= dflt_period;
      r.window    <= dflt_window;
      r.offset    <= dflt_offset;
      r.irq_en    <= 1'b0;
    end else begin
      r.always_on <= ao_next;
      if (ctrl_we) begin
        if (ctrl_enable)   r.enable <= 1'b1;
        else if (!ao_next) r.enable <= 1'b0;
        if (unlocked)      r.win_en <= ctrl_win_en;
      end
      if (cfg_we && unlocked) begin
        r.period <= cfg_period;
        r.window <= cfg_window;
      end
      if (ew_we && unlocked) r.offset <= ew_offset;
      if (ie_we)             r.irq_en <= ie_val;
    end
  end

  assign cfg_o = r;

endmodule

// File: rtl/wwd_counter.sv
module wwd_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             win_en,
  input  logic             tick,
  input  logic             kick,
  input  logic [CNT_W-1:0] per_ticks,
  input  logic [CNT_W-1:0] win_ticks,
  input  logic [CNT_W-1:0] off_ticks,
  output logic             fire_o,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] limit;
  logic             armed;
  logic             closed;
  logic             expire;
  logic             early_kick;
  logic             restart;

  always_comb begin
    nxt        = cnt + 1'b1;
    limit      = win_en ? (win_ticks + per_ticks) : per_ticks;
    closed     = win_en && (cnt < win_ticks);
    expire     = en && !kick && tick && (nxt == limit);
    early_kick = en && kick && closed;
    restart    = en && (kick || expire);
    fire_o     = expire || early_kick;
    hit_o      = en && !kick && tick && !expire && armed && (nxt == off_ticks);
  end

  always_ff @(posedge clk) begin
    if (rst || !en || restart) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (tick) begin
      cnt <= nxt;
      if (hit_o) armed <= 1'b0;
    end
  end

endmodule

// File: rtl/wwd_top.sv
module wwd_top #(
  parameter int BASE_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       kick,
  input  logic       ctrl_we,
  input  logic       ctrl_enable,
  input  logic       ctrl_always_on,
  input  logic       ctrl_win_en,
  input  logic       cfg_we,
  input  logic [3:0] cfg_period,
  input  logic [3:0] cfg_window,
  input  logic       ew_we,
  input  logic [3:0] ew_offset,
  input  logic       ie_we,
  input  logic       ie_val,
  input  logic       ew_clr,
  input  logic       dflt_enable,
  input  logic       dflt_always_on,
  input  logic       dflt_win_en,
  input  logic [3:0] dflt_period,
  input  logic [3:0] dflt_window,
  input  logic [3:0] dflt_offset,
  output logic       enable_o,
  output logic       always_on_o,
  output logic       win_en_o,
  output logic [3:0] period_o,
  output logic [3:0] window_o,
  output logic [3:0] offset_o,
  output logic       irq_en_o,
  output logic       sys_rst_req,
  output logic       ew_flag
);
  import wwd_pkg::*;

  localparam int MAX_TICKS = BASE_TICKS << TOP_CODE;
  localparam int CNT_W     = $clog2(2 * MAX_TICKS + 1);
  localparam int N_DEC     = 3;

  wwd_cfg_t         cfg;
  code_t            codes [N_DEC];
  logic [CNT_W-1:0] ticks [N_DEC];
  logic             fire;
  logic             hit;

  wwd_cfg_regs u_regs (
    .clk(clk), .rst(rst),
    .ctrl_we(ctrl_we), .ctrl_enable(ctrl_enable),
    .ctrl_always_on(ctrl_always_on), .ctrl_win_en(ctrl_win_en),
    .cfg_we(cfg_we), .cfg_period(cfg_period), .cfg_window(cfg_window),
    .ew_we(ew_we), .ew_offset(ew_offset),
    .ie_we(ie_we), .ie_val(ie_val),
    .dflt_enable(dflt_enable), .dflt_always_on(dflt_always_on),
    .dflt_win_en(dflt_win_en), .dflt_period(dflt_period),
    .dflt_window(dflt_window), .dflt_offset(dflt_offset),
    .cfg_o(cfg)
  );

  assign codes[0] = cfg.period;
  assign codes[1] = cfg.window;
  assign codes[2] = cfg.offset;

  for (genvar g = 0; g < N_DEC; g++) begin : g_dec
    wwd_period_dec #(.BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)) u_dec (
      .code_i (codes[g]),
      .ticks_o(ticks[g])
    );
  end

  wwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .en(cfg.enable), .win_en(cfg.win_en),
    .tick(tick_en), .kick(kick),
    .per_ticks(ticks[0]), .win_ticks(ticks[1]), .off_ticks(ticks[2]),
    .fire_o(fire), .hit_o(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_rst_req <= 1'b0;
      ew_flag     <= 1'b0;
    end else begin
      sys_rst_req <= fire;
      if (hit && cfg.irq_en) ew_flag <= 1'b1;
      else if (ew_clr)       ew_flag <= 1'b0;
    end
  end

  assign enable_o    = cfg.enable;
  assign always_on_o = cfg.always_on;
  assign win_en_o    = cfg.win_en;
  assign period_o    = cfg.period;
  assign window_o    = cfg.window;
  assign offset_o    = cfg.offset;
  assign irq_en_o    = cfg.irq_en;

endmodule

// File: rtl/wwd_checker.sv
module wwd_checker (
  input logic       clk,
  input logic       rst,
  input logic       kick,
  input logic       ew_clr,
  input logic       enable_o,
  input logic       always_on_o,
  input logic       win_en_o,
  input logic [3:0] period_o,
  input logic [3:0] window_o,
  input logic [3:0] offset_o,
  input logic       irq_en_o,
  input logic       sys_rst_req,
  input logic       ew_flag
);

  p_cfg_locked_r2: assert property (@(posedge clk) disable iff (rst)
    enable_o |=> ($stable(period_o) && $stable(window_o) &&
                  $stable(offset_o) && $stable(win_en_o)));

  p_always_on_r3: assert property (@(posedge clk) disable iff (rst)
    (enable_o && always_on_o) |=> (enable_o && always_on_o));

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (sys_rst_req && !kick) |=> !sys_rst_req);

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !enable_o |=> !sys_rst_req);

  p_flag_gate_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ew_flag) |-> $past(irq_en_o));

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (ew_flag && !ew_clr) |=> ew_flag);

endmodule

bind wwd_top wwd_checker u_chk (
  .clk(clk), .rst(rst), .kick(kick), .ew_clr(ew_clr),
  .enable_o(enable_o), .always_on_o(always_on_o), .win_en_o(win_en_o),
  .period_o(period_o), .window_o(window_o), .offset_o(offset_o),
  .irq_en_o(irq_en_o), .sys_rst_req(sys_rst_req), .ew_flag(ew_flag)
);

// File: tb/sim_wwd_top.sv
`timescale 1ns/1ps
module sim_wwd_top;

  localparam int BASE = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b1, kick = 1'b0;
  logic ctrl_we = 1'b0, ctrl_enable = 1'b0, ctrl_always_on = 1'b0, ctrl_win_en = 1'b0;
  logic cfg_we = 1'b0; logic [3:0] cfg_period = '0, cfg_window = '0;
  logic ew_we = 1'b0;  logic [3:0] ew_offset = '0;
  logic ie_we = 1'b0, ie_val = 1'b0, ew_clr = 1'b0;
  logic dflt_enable = 1'b0, dflt_always_on = 1'b0, dflt_win_en = 1'b0;
  logic [3:0] dflt_period = 4'd2, dflt_window = 4'd1, dflt_offset = 4'd1;
  logic enable_o, always_on_o, win_en_o, irq_en_o, sys_rst_req, ew_flag;
  logic [3:0] period_o, window_o, offset_o;

  int checks = 0;
  int errors = 0;
  int tick_every = 1;
  int tick_cnt = 0;

  always #10 clk = ~clk;

  wwd_top #(.BASE_TICKS(BASE)) u0 (.*);

  // ---------------- behavioural reference model ----------------
  int m_en, m_ao, m_wen, m_per, m_win, m_off, m_ie;
  int m_cnt, m_armed, m_flag, m_rst;

  function automatic int tk(input int c);
    return BASE * (1 << ((c > 11) ? 11 : c));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = dflt_enable; m_ao = dflt_always_on; m_wen = dflt_win_en;
      m_per = dflt_period; m_win = dflt_window; m_off = dflt_offset;
      m_ie = 0; m_cnt = 0; m_armed = 1; m_flag = 0; m_rst = 0;
    end else begin
      int fire, hit, lim, n, ao2;
      fire = 0; hit = 0;
      if (!m_en) begin
        m_cnt = 0; m_armed = 1;
      end else if (kick) begin
        if (m_wen != 0 && m_cnt < tk(m_win)) fire = 1;
        m_cnt = 0; m_armed = 1;
      end else if (tick_en) begin
        n   = m_cnt + 1;
        lim = m_wen != 0 ? tk(m_win) + tk(m_per) : tk(m_per);
        if (n == lim) begin
          fire = 1; m_cnt = 0; m_armed = 1;
        end else begin
          if (m_armed != 0 && n == tk(m_off)) begin hit = 1; m_armed = 0; end
          m_cnt = n;
        end
      end
      m_rst = fire;
      if (hit != 0 && m_ie != 0) m_flag = 1;
      else if (ew_clr) m_flag = 0;
      ao2 = m_ao | (ctrl_we & ctrl_always_on);
      if (ctrl_we) begin
        if (!m_en) m_wen = ctrl_win_en;
        if (ctrl_enable) m_en = 1; else if (ao2 == 0) m_en = 0;
        // protection above uses the enable seen before this write
      end
      m_ao = ao2;
      if (cfg_we && m_en_prev_unlocked()) begin m_per = cfg_period; m_win = cfg_window; end
      if (ew_we && m_en_prev_unlocked()) m_off = ew_offset;
      if (ie_we) m_ie = ie_val;
      m_prev_en = m_en;
    end
  end

  // enable as it stood before the current edge's writes
  int m_prev_en = 0;
  function automatic bit m_en_prev_unlocked();
    return (m_prev_en == 0);
  endfunction

  // ---------------- helpers ----------------
  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
    if (!rst) begin
      checks++;
      if (sys_rst_req !== 1'(m_rst) || ew_flag !== 1'(m_flag) ||
          enable_o !== 1'(m_en) || always_on_o !== 1'(m_ao) ||
          win_en_o !== 1'(m_wen) || period_o !== 4'(m_per) ||
          window_o !== 4'(m_win) || offset_o !== 4'(m_off) || irq_en_o !== 1'(m_ie)) begin
        errors++;
        $display("FAIL R10 model compare t=%0t actual rst=%b flag=%b en=%b expected rst=%0d flag=%0d en=%0d",
                 $time, sys_rst_req, ew_flag, enable_o, m_rst, m_flag, m_en);
      end
    end
    kick = 0; ctrl_we = 0; cfg_we = 0; ew_we = 0; ie_we = 0; ew_clr = 0;
    tick_cnt++;
    tick_en = ((tick_cnt % tick_every) == 0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic steps_to_pulse(output int n, input int lim);
    n = 0;
    for (int i = 0; i < lim; i++) begin
      step(); n++;
      if (sys_rst_req) break;
    end
  endtask

  task automatic ctrl(input logic en, input logic ao, input logic wen);
    ctrl_we = 1; ctrl_enable = en; ctrl_always_on = ao; ctrl_win_en = wen;
  endtask

  task automatic do_reset();
    rst = 1; m_prev_en = dflt_enable;
    run(3);
    rst = 0;
    step();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int n, pulses;
    do_reset();
    m_prev_en = m_en;
    // R1 reset state
    chk("R1 enable", enable_o, 0);
    chk("R1 period", period_o, 2);
    chk("R1 window", window_o, 1);
    chk("R1 offset", offset_o, 1);
    chk("R1 irq_en/flag/req", {irq_en_o, ew_flag, sys_rst_req}, 0);

    // R9 disabled: kicks and ticks do nothing
    tick_every = 3; pulses = 0;
    for (int i = 0; i < 60; i++) begin
      kick = (i % 7 == 0); step();
      if (sys_rst_req) pulses++;
    end
    chk("R9 no request while off", pulses, 0);
    tick_every = 1;

    // R2 writes while disabled take effect
    cfg_we = 1; cfg_period = 4'd1; cfg_window = 4'd0; ew_we = 1; ew_offset = 4'd0;
    step();
    chk("R2 period written when off", period_o, 1);
    chk("R2 offset written when off", offset_o, 0);

    // R3/R4 enable and normal time-out of 16 ticks
    ctrl(1, 0, 0); step();
    chk("R3 enable set", enable_o, 1);
    steps_to_pulse(n, 100);
    chk("R4 normal timeout ticks", n, 16);
    step();
    chk("R4 single-cycle request", sys_rst_req, 0);
    chk("R8 flag gated by irq enable", ew_flag, 0);

    // R2 writes while enabled are ignored
    cfg_we = 1; cfg_period = 4'd5; cfg_window = 4'd3; ew_we = 1; ew_offset = 4'd4;
    step();
    ctrl(1, 0, 1); step();
    chk("R2 period locked", period_o, 1);
    chk("R2 window locked", window_o, 0);
    chk("R2 offset locked", offset_o, 0);
    chk("R2 win_en locked", win_en_o, 0);

    // R8 warning flag with interrupt enabled
    ie_we = 1; ie_val = 1; kick = 1; step();
    run(7);
    chk("R8 flag not yet", ew_flag, 0);
    step();
    chk("R8 flag at offset", ew_flag, 1);
    ew_clr = 1; step();
    chk("R8 flag cleared", ew_flag, 0);
    run(3);
    chk("R8 no second set before restart", ew_flag, 0);

    // R5 kicks keep it alive, with gapped ticks
    tick_every = 2; pulses = 0;
    for (int i = 0; i < 120; i++) begin
      kick = (i % 9 == 0); step();
      if (sys_rst_req) pulses++;
    end
    chk("R5 periodic kicks prevent request", pulses, 0);
    tick_every = 1;

    // R5 kick on the expiring tick wins
    kick = 1; step();
    run(15);
    chk("R5 no request at count 15", sys_rst_req, 0);
    kick = 1; step();
    chk("R5 kick beats expiry", sys_rst_req, 0);
    step();
    chk("R5 still no request after collision", sys_rst_req, 0);

    // R3 disable, then R6/R7 window mode: window 8, period 8
    ctrl(0, 0, 0); step();
    chk("R3 disable without always-on", enable_o, 0);
    ctrl(0, 0, 1); cfg_we = 1; cfg_period = 4'd0; cfg_window = 4'd0; step();
    chk("R2 win_en written when off", win_en_o, 1);
    ctrl(1, 0, 1); step();
    run(3);
    kick = 1; step();
    chk("R6 early kick requests reset", sys_rst_req, 1);
    run(10);
    kick = 1; step();
    chk("R7 open kick accepted", sys_rst_req, 0);
    steps_to_pulse(n, 100);
    chk("R7 window+period expiry", n, 16);

    // R3 always-on lock
    ctrl(1, 1, 1); step();
    ctrl(0, 0, 1); step();
    chk("R3 disable refused when always-on", enable_o, 1);
    chk("R3 always-on sticky", always_on_o, 1);

    // R1/R4 second reset with enabled defaults and saturating code 13
    dflt_enable = 1; dflt_always_on = 0; dflt_win_en = 0; dflt_period = 4'd13;
    dflt_window = 4'd2; dflt_offset = 4'd15;
    do_reset();
    m_prev_en = m_en;
    chk("R1 enable from default", enable_o, 1);
    chk("R1 always-on cleared by reset", always_on_o, 0);
    steps_to_pulse(n, 20000);
    chk("R4 code 13 saturates to 11", n, 16383);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule